// File: doc/BRIEF.md
# Slot-Table DMA Scheduler

This block chooses which DMA channel, and in which direction, receives each transfer slot. Arbitration does not rotate over the requesters. Software fills a slot table, and the block walks that table in order. Each table entry is one byte that names a channel and a direction (transmit or receive). Four entries are packed into each 32-bit table word.

A small register bus gives access to the table and to one control register. The control register holds an enable bit and the index of the last valid entry. When the block is enabled, it examines one entry per clock and wraps back to entry 0 after the last index. It pulses a grant for the named channel and direction only if the matching request line is high. An entry whose request is low is skipped, and no grant is issued for it.

A typical table gives every channel a transmit slot followed by a receive slot. With 30 channels this is 60 entries, and the last index is 59. Disabling the block is done by writing zero to the control register. After state is lost, software must reload the table and enable the block again.

Top module: `slot_sched`

## Requirements
- R1: After reset the block is disabled. No grant is issued, and the control register and every table word read as zero.
- R2: The control register is at byte offset 0. Bit 31 is the enable bit and bits [IDX_W-1:0] hold the last valid entry index. A read returns the last written values of these fields, and all other bits read as zero.
- R3: Table word w is at byte offset 0x800 + 4*w. Entry i is held in word i/4, in byte i%4, with byte 0 in bits [7:0]. A read returns the last written word.
- R4: In an entry byte, bits [6:0] give the channel number. Bit 7 set means receive, and bit 7 clear means transmit. A grant reports that channel on grant_ch_o and that direction on grant_rx_o.
- R5: The enable write takes effect at clock edge E0. At edge E0+1+k the grant outputs show the result for entry k. Entries are examined one per clock in ascending order.
- R6: After the entry at the last index, the walk continues at entry 0. This holds for any programmed last index.
- R7: A grant is issued only when the request line for that channel in the entry's direction is high. A request in the other direction has no effect on the slot, and a slot with no matching request produces no grant.
- R8: An entry whose channel number is NUM_CH or higher never produces a grant.
- R9: A control write that clears the enable bit lands at edge D. From edge D+1 onward no grant is issued. A later enable restarts the walk at entry 0.
- R10: Table writes made while the block is disabled are used by the walk that starts at the next enable.
- R11: Reads of unmapped offsets return zero. This includes word indices at or above MAX_ENTRIES/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| tx_req_i | input | NUM_CH | Transmit request per channel |
| rx_req_i | input | NUM_CH | Receive request per channel |
| grant_valid_o | output | 1 | One-cycle grant pulse |
| grant_ch_o | output | CH_W | Granted channel |
| grant_rx_o | output | 1 | Granted direction, 1 = receive |

## Verification
The assertions assume that the request vectors are sampled at the clock edge that examines a slot. A grant is therefore checked against the request values one cycle earlier. The assertions also assume that register accesses are single-cycle strobes. The bench drives requests and bus strobes only on falling edges and issues one bus access at a time. It keeps the request vectors constant during each walk, so the expected grant for every slot follows from the table contents alone.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int unsigned CTRL_EN_BIT = 31;
  localparam int unsigned ENTRY_W     = 8;

  typedef struct packed {
    logic       rx;
    logic [6:0] ch;
  } slot_t;
endpackage

// File: rtl/slot_sched_regs.sv
module slot_sched_regs
  import slot_sched_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned WORDS  = 64,
  parameter int unsigned WIDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              en_o,
  output logic [IDX_W-1:0]  last_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_entry_o
);
  logic [31:0]       tbl_q [WORDS];
  logic              en_q;
  logic [IDX_W-1:0]  last_q;
  logic [31:0]       rdata_q;
  logic              ctrl_hit, tbl_hit, wr, rd;
  logic [WIDX_W-1:0] widx;
  logic [31:0]       rd_mux, cur_word;

  assign wr       = reg_en_i & reg_we_i;
  assign rd       = reg_en_i & ~reg_we_i;
  assign ctrl_hit = (reg_addr_i == '0);
  assign widx     = reg_addr_i[WIDX_W+1:2];

  // table window: top address bit set, no bits between window and word index
  generate
    if (ADDR_W - 2 > WIDX_W + 2) begin : g_hi
      assign tbl_hit = reg_addr_i[ADDR_W-1] && (reg_addr_i[ADDR_W-2:WIDX_W+2] == '0)
                       && (reg_addr_i[1:0] == 2'b00);
    end else begin : g_flat
      assign tbl_hit = reg_addr_i[ADDR_W-1] && (reg_addr_i[1:0] == 2'b00);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      last_q <= '0;
    end else if (wr && ctrl_hit) begin
      en_q   <= reg_wdata_i[CTRL_EN_BIT];
      last_q <= reg_wdata_i[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < int'(WORDS); w++) tbl_q[w] <= '0;
    end else if (wr && tbl_hit) begin
      tbl_q[widx] <= reg_wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) begin
      rd_mux[CTRL_EN_BIT] = en_q;
      rd_mux[IDX_W-1:0]   = last_q;
    end else if (tbl_hit) begin
      rd_mux = tbl_q[widx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign cur_word    = tbl_q[rd_idx_i[IDX_W-1:2]];
  assign rd_entry_o  = cur_word[8*rd_idx_i[1:0] +: 8];
  assign reg_rdata_o = rdata_q;
  assign en_o        = en_q;
  assign last_o      = last_q;
endmodule

// File: rtl/slot_sched_walk.sv
module slot_sched_walk #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ptr_q <= '0;
    else if (!en_i)            ptr_q <= '0;
    else if (ptr_q >= last_i)  ptr_q <= '0;  // also covers last lowered mid-walk
    else                       ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/slot_sched_grant.sv
module slot_sched_grant
  import slot_sched_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [7:0]        entry_i,
  input  logic [NUM_CH-1:0] tx_req_i,
  input  logic [NUM_CH-1:0] rx_req_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              rx_o
);
  slot_t           slot;
  logic            in_range, hit;
  logic            valid_q, rx_q;
  logic [CH_W-1:0] ch_q;

  assign slot     = slot_t'(entry_i);
  assign in_range = (32'(slot.ch) < NUM_CH);

  always_comb begin
    hit = 1'b0;
    if (in_range) hit = slot.rx ? rx_req_i[slot.ch[CH_W-1:0]] : tx_req_i[slot.ch[CH_W-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ch_q    <= '0;
      rx_q    <= 1'b0;
    end else begin
      valid_q <= en_i & hit;
      if (en_i & hit) begin
        ch_q <= slot.ch[CH_W-1:0];
        rx_q <= slot.rx;
      end
    end
  end

  assign valid_o = valid_q;
  assign ch_o    = ch_q;
  assign rx_o    = rx_q;
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned MAX_ENTRIES = 256,
  parameter int unsigned ADDR_W      = 12,
  localparam int unsigned IDX_W      = $clog2(MAX_ENTRIES),
  localparam int unsigned WORDS      = MAX_ENTRIES / 4,
  localparam int unsigned WIDX_W     = $clog2(WORDS),
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [NUM_CH-1:0] tx_req_i,
  input  logic [NUM_CH-1:0] rx_req_i,
  output logic              grant_valid_o,
  output logic [CH_W-1:0]   grant_ch_o,
  output logic              grant_rx_o
);
  logic             en_w;
  logic [IDX_W-1:0] last_w;
  logic [IDX_W-1:0] ptr_w;
  logic [7:0]       entry_w;

  slot_sched_regs #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .WORDS  (WORDS),
    .WIDX_W (WIDX_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_en_i    (reg_en_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .en_o        (en_w),
    .last_o      (last_w),
    .rd_idx_i    (ptr_w),
    .rd_entry_o  (entry_w)
  );

  slot_sched_walk #(
    .IDX_W (IDX_W)
  ) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .last_i (last_w),
    .ptr_o  (ptr_w)
  );

  slot_sched_grant #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_grant (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .entry_i  (entry_w),
    .tx_req_i (tx_req_i),
    .rx_req_i (rx_req_i),
    .valid_o  (grant_valid_o),
    .ch_o     (grant_ch_o),
    .rx_o     (grant_rx_o)
  );
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CH_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] tx_req_i,
  input logic [NUM_CH-1:0] rx_req_i,
  input logic              grant_valid_o,
  input logic [CH_W-1:0]   grant_ch_o,
  input logic              grant_rx_o,
  input logic              en_i,
  input logic [IDX_W-1:0]  ptr_i,
  input logic [IDX_W-1:0]  last_i
);
  logic [NUM_CH-1:0] prev_tx, prev_rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_tx <= '0;
      prev_rx <= '0;
    end else begin
      prev_tx <= tx_req_i;
      prev_rx <= rx_req_i;
    end
  end

  assert_grant_has_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_rx_o ? prev_rx[grant_ch_o] : prev_tx[grant_ch_o]));

  assert_idle_no_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !grant_valid_o);

  assert_idle_ptr_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (ptr_i == '0));

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && ptr_i != '0) |-> (ptr_i == $past(ptr_i) + IDX_W'(1)));

  assert_ptr_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && ($past(ptr_i) >= $past(last_i))) |-> (ptr_i == '0));
endmodule

bind slot_sched slot_sched_chk #(
  .NUM_CH (NUM_CH),
  .IDX_W  (IDX_W),
  .CH_W   (CH_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_req_i      (tx_req_i),
  .rx_req_i      (rx_req_i),
  .grant_valid_o (grant_valid_o),
  .grant_ch_o    (grant_ch_o),
  .grant_rx_o    (grant_rx_o),
  .en_i          (en_w),
  .ptr_i         (ptr_w),
  .last_i        (last_w)
);

// File: tb/slot_sched_tb_top.sv
`timescale 1ns/1ps
module slot_sched_tb_top;
  localparam int unsigned NUM_CH = 32;
  localparam int unsigned CH_W   = 5;

  // {expected grant, entry byte}; requests fixed below
  localparam logic [8:0] VEC [8] = '{
    9'h1_00,  // tx ch0, requested
    9'h0_80,  // rx ch0, only tx requested (R7)
    9'h1_01,  // tx ch1
    9'h1_81,  // rx ch1
    9'h0_02,  // tx ch2, not requested
    9'h1_82,  // rx ch2
    9'h1_9F,  // rx ch31
    9'h0_20   // ch32 out of range (R8)
  };
  localparam logic [NUM_CH-1:0] TX_REQ = 32'h0000_000B;
  localparam logic [NUM_CH-1:0] RX_REQ = 32'h8000_0006;

  logic clk, rst_n;
  logic reg_en, reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NUM_CH-1:0] tx_req, rx_req;
  logic g_valid, g_rx;
  logic [CH_W-1:0] g_ch;
  int nchk, nfail;
  bit done;

  slot_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_req_i(tx_req), .rx_req_i(rx_req),
    .grant_valid_o(g_valid), .grant_ch_o(g_ch), .grant_rx_o(g_rx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_slot(input string tag, input logic [8:0] v);
    chk({tag, " valid"}, {31'd0, g_valid}, {31'd0, v[8]});
    if (v[8]) begin
      chk({tag, " ch"}, {27'd0, g_ch}, {27'd0, v[4:0]});
      chk({tag, " dir"}, {31'd0, g_rx}, {31'd0, v[7]});
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [8:0] v3 [3];
    nchk = 0; nfail = 0; done = 1'b0;
    rst_n = 1'b0; reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_req = '0; rx_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 grant", {31'd0, g_valid}, 32'd0);
    reg_rd(12'h000, rd); chk("R1 ctrl", rd, 32'd0);
    reg_rd(12'h800, rd); chk("R1 word0", rd, 32'd0);

    // R2 ctrl readback, upper bits dropped, stays disabled
    reg_wr(12'h000, 32'h0000_FF07);
    reg_rd(12'h000, rd); chk("R2 ctrl", rd, 32'h0000_0007);

    // R3 program table, readback packing
    reg_wr(12'h800, {VEC[3][7:0], VEC[2][7:0], VEC[1][7:0], VEC[0][7:0]});
    reg_wr(12'h804, {VEC[7][7:0], VEC[6][7:0], VEC[5][7:0], VEC[4][7:0]});
    reg_rd(12'h800, rd); chk("R3 word0", rd, 32'h8101_8000);
    reg_rd(12'h804, rd); chk("R3 word1", rd, 32'h209F_8202);
    // R11 unmapped
    reg_rd(12'h004, rd); chk("R11 off4", rd, 32'd0);
    reg_rd(12'h900, rd); chk("R11 word64", rd, 32'd0);
    chk("R1 no grant while disabled", {31'd0, g_valid}, 32'd0);

    // R4 R5 R6 R7 R8: vector walk, two laps
    tx_req = TX_REQ; rx_req = RX_REQ;
    reg_wr(12'h000, 32'h8000_0007);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      chk_slot($sformatf("R5/R6 slot %0d (R4 R7 R8)", k % 8), VEC[k % 8]);
    end

    // R9 disable
    reg_wr(12'h000, 32'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 no grant after disable", {31'd0, g_valid}, 32'd0);
    end

    // R10 table change while disabled, R9 restart at entry 0
    reg_wr(12'h800, 32'h8101_8003);
    reg_wr(12'h000, 32'h8000_0002);
    v3[0] = 9'h1_03; v3[1] = 9'h0_80; v3[2] = 9'h1_01;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk_slot($sformatf("R10/R6 short slot %0d", k % 3), v3[k % 3]);
    end

    // R7 no requests -> no grants
    tx_req = '0; rx_req = '0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 idle requests", {31'd0, g_valid}, 32'd0);
    end

    // R7 only opposite direction for ch3 slot (tx entry)
    rx_req = 32'h0000_0008;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7 opposite dir ignored", {31'd0, g_valid}, 32'd0);
    end

    reg_wr(12'h000, 32'h0);
    reg_rd(12'h000, rd); chk("R2 ctrl cleared", rd, 32'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule